// File: doc/BRIEF.md
# Segmented Parallel Prefix Scanner

This block computes an inclusive segmented prefix over a vector of `N` lanes. Each lane carries a 16-bit value and a head flag that marks the first lane of a segment. The vector is taken in one cycle when `start_i` is high. It is then folded in log2(N) doubling stages, one stage per clock. In stage k each lane takes the partial result held by the lane 2^k places earlier in scan order, unless a segment head lies between them. The finished vector is returned on `result_o` together with a one-cycle `done_o` pulse.

Two operators are available. The add operator gives running sums that wrap modulo 2^16 and restart at every head. The copy operator spreads the value of each segment head over the rest of its segment. A direction input reverses the scan order. Scan order then runs from the highest lane down to lane 0, and a head restarts the scan for the lanes below it.

Top module: `seg_scan_engine`

## Requirements
- R1: The scan takes log2(N) stages, one per clock, and in stage k a lane receives from the lane 2^k earlier in scan order. `done_o` rises exactly log2(N)+1 clock edges after the edge that samples `start_i` high.
- R2: A lane with no lane 2^k earlier in scan order receives nothing in stage k. The first lane in scan order therefore always returns its own input value.
- R3: With `op_i` = 0 (add), each result lane holds the wrapped 16-bit sum of all values from its segment head up to and including itself. Lanes 1,2,3,4 with no heads give 1,3,6,10.
- R4: A lane whose `head_i` bit is 1 starts a new segment. Its result depends only on its own value, and no value from a lane before it in scan order reaches it or any later lane of its segment. When every lane is a head, the result equals the input.
- R5: With `op_i` = 1 (copy), each result lane equals the input value of the nearest head at or before it in scan order. Lanes before the first head take the value of the first lane in scan order.
- R6: With `rev_i` = 0, scan order runs from lane 0 up to lane N-1. With `rev_i` = 1, it runs from lane N-1 down to lane 0, and R2 to R5 then apply in that order.
- R7: `done_o` is high for exactly one cycle per accepted start. A `start_i` that arrives while a scan is in its stages is ignored: it produces no second `done_o`, and the result is that of the first start.
- R8: After reset, `done_o` is 0 and `result_o` is all zeros. `result_o` changes only on the edge that raises `done_o`, and it holds its value while inputs change without an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Accept the input vector and begin a scan |
| op_i | input | 1 | Operator: 0 add, 1 copy |
| rev_i | input | 1 | Scan order: 0 low-to-high, 1 high-to-low |
| data_i | input | N*W | Lane values, lane i at bits [i*W +: W] |
| head_i | input | N | Segment-head flag per lane |
| done_o | output | 1 | One-cycle pulse when `result_o` is updated |
| result_o | output | N*W | Registered scan result, same lane layout as `data_i` |

## Verification
An ascending vector without heads tests the doubling distances. A wrong partner offset or a missing stage changes the running sums. Head masks placed mid-vector, on the first lane and on every lane test whether a boundary stops contributions in every stage or only in the first one. Copy runs with and without a leading head test the operator and its fill-before-first-head rule. The same masks in reverse order, a wrap-around sum, a start issued during a running scan and input changes after completion test direction handling, modular arithmetic, start rejection and output holding.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic {
    SCAN_ADD  = 1'b0,
    SCAN_COPY = 1'b1
  } scan_op_e;
endpackage

// File: rtl/scan_reorder.sv
module scan_reorder #(
  parameter int N = 8,
  parameter int W = 16
) (
  input  logic         rev,
  input  logic [N*W-1:0] d,
  output logic [N*W-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_lane
    assign q[i*W +: W] = rev ? d[(N-1-i)*W +: W] : d[i*W +: W];
  end
endmodule

// File: rtl/scan_cell.sv
module scan_cell
  import scan_pkg::*;
#(
  parameter int W = 16
) (
  input  scan_op_e       op,
  input  logic           has_src,
  input  logic [W-1:0]   own_val,
  input  logic           own_head,
  input  logic [W-1:0]   src_val,
  input  logic           src_head,
  output logic [W-1:0]   nxt_val,
  output logic           nxt_head
);
  always_comb begin
    nxt_val  = own_val;
    nxt_head = own_head;
    if (has_src && !own_head) begin
      nxt_val  = (op == SCAN_ADD) ? (src_val + own_val) : src_val;
      nxt_head = src_head;
    end
  end
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl #(
  parameter int STAGES = 3,
  localparam int SW = (STAGES > 1) ? $clog2(STAGES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          load,
  output logic          busy,
  output logic [SW-1:0] stg,
  output logic          wr
);
  localparam logic [SW-1:0] LAST = SW'(STAGES - 1);

  assign load = start && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      stg  <= '0;
      wr   <= 1'b0;
    end else begin
      wr <= 1'b0;
      if (load) begin
        busy <= 1'b1;
        stg  <= '0;
      end else if (busy) begin
        if (stg == LAST) begin
          busy <= 1'b0;
          wr   <= 1'b1;
        end else begin
          stg <= stg + 1'b1;
        end
      end
    end
  end

  AST_STAGE_STEP: assert property (@(posedge clk) disable iff (rst)
    (busy && stg != LAST) |=> (busy && stg == $past(stg) + 1'b1)); // R1
  AST_STAGE_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy |-> (stg <= LAST)); // R1
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy || wr)); // R7
endmodule

// File: rtl/seg_scan_engine.sv
module seg_scan_engine
  import scan_pkg::*;
#(
  parameter int N = 8,
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_i,
  input  logic           op_i,
  input  logic           rev_i,
  input  logic [N*W-1:0] data_i,
  input  logic [N-1:0]   head_i,
  output logic           done_o,
  output logic [N*W-1:0] result_o
);
  localparam int STAGES = $clog2(N);
  localparam int SW = (STAGES > 1) ? $clog2(STAGES) : 1;

  logic           load, busy, wr;
  logic [SW-1:0]  stg;
  logic [N*W-1:0] ord_val, nxt_val, work_val, res_nxt;
  logic [N-1:0]   ord_head, nxt_head, work_head;
  scan_op_e       op_q;
  logic           rev_q;

  scan_ctrl #(.STAGES(STAGES)) u_ctrl (
    .clk(clk), .rst(rst), .start(start_i),
    .load(load), .busy(busy), .stg(stg), .wr(wr)
  );

  scan_reorder #(.N(N), .W(W)) u_in_val  (.rev(rev_i), .d(data_i), .q(ord_val));
  scan_reorder #(.N(N), .W(1)) u_in_head (.rev(rev_i), .d(head_i), .q(ord_head));
  scan_reorder #(.N(N), .W(W)) u_out_val (.rev(rev_q), .d(work_val), .q(res_nxt));

  for (genvar i = 0; i < N; i++) begin : g_lane
    logic         has_src;
    logic [W-1:0] src_val;
    logic         src_head;

    always_comb begin
      has_src  = 1'b0;
      src_val  = '0;
      src_head = 1'b0;
      for (int k = 0; k < STAGES; k++) begin
        if (int'(stg) == k && i >= (1 << k)) begin
          has_src  = 1'b1;
          src_val  = work_val[(i - (1 << k))*W +: W];
          src_head = work_head[i - (1 << k)];
        end
      end
    end

    scan_cell #(.W(W)) u_cell (
      .op(op_q), .has_src(has_src),
      .own_val(work_val[i*W +: W]), .own_head(work_head[i]),
      .src_val(src_val), .src_head(src_head),
      .nxt_val(nxt_val[i*W +: W]), .nxt_head(nxt_head[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      work_val  <= '0;
      work_head <= '0;
      op_q      <= SCAN_ADD;
      rev_q     <= 1'b0;
    end else if (load) begin
      work_val  <= ord_val;
      work_head <= ord_head;
      op_q      <= scan_op_e'(op_i);
      rev_q     <= rev_i;
    end else if (busy) begin
      work_val  <= nxt_val;
      work_head <= nxt_head;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= wr;
      if (wr) result_o <= res_nxt;
    end
  end

  AST_FIRST_LANE: assert property (@(posedge clk) disable iff (rst)
    busy |=> (work_val[W-1:0] == $past(work_val[W-1:0]))); // R2
  AST_HEAD_STICKY: assert property (@(posedge clk) disable iff (rst)
    busy |=> ((work_head & $past(work_head)) == $past(work_head))); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(result_o)); // R8
endmodule

// File: tb/sim_seg_scan_engine.sv
module sim_seg_scan_engine;
  localparam int N = 8;
  localparam int W = 16;
  localparam int LOGN = $clog2(N);

  logic           clk = 1'b0;
  logic           rst;
  logic           start_i, op_i, rev_i;
  logic [N*W-1:0] data_i;
  logic [N-1:0]   head_i;
  logic           done_o;
  logic [N*W-1:0] result_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  seg_scan_engine #(.N(N), .W(W)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .rev_i(rev_i),
    .data_i(data_i), .head_i(head_i), .done_o(done_o), .result_o(result_o)
  );

  function automatic logic [N*W-1:0] model(input logic op, input logic rev,
                                           input logic [N*W-1:0] d, input logic [N-1:0] h);
    logic [N*W-1:0] e;
    logic [W-1:0]   acc;
    e   = '0;
    acc = '0;
    for (int p = 0; p < N; p++) begin
      int i;
      i = rev ? (N - 1 - p) : p;
      if (p == 0 || h[i]) acc = d[i*W +: W];
      else if (!op)       acc = acc + d[i*W +: W];
      e[i*W +: W] = acc;
    end
    return e;
  endfunction

  task automatic check_vec(input string tag, input string what,
                           input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      for (int i = 0; i < N; i++) begin
        if (act[i*W +: W] !== exp[i*W +: W]) begin
          $display("FAIL %s %s lane %0d: actual %h expected %h", tag, what, i,
                   act[i*W +: W], exp[i*W +: W]);
          break;
        end
      end
    end
  endtask

  task automatic check_int(input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Issue one scan, check latency (R1), the pulse width (R7) and the result.
  task automatic run_scan(input string tag, input logic op, input logic rev,
                          input logic [N*W-1:0] d, input logic [N-1:0] h);
    int lat;
    logic [N*W-1:0] exp;
    exp = model(op, rev, d, h);
    @(negedge clk);
    start_i = 1'b1; op_i = op; rev_i = rev; data_i = d; head_i = h;
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 64) begin
      @(negedge clk);
      lat++;
    end
    check_int("R1", "edges from start to done", lat, LOGN + 1);
    check_vec(tag, "result", result_o, exp);
    @(negedge clk);
    check_int("R7", "done width", int'(done_o), 0);
  endtask

  task automatic t_reset();
    check_int("R8", "done after reset", int'(done_o), 0);
    check_vec("R8", "result after reset", result_o, '0);
  endtask

  task automatic t_add_plain();
    logic [N*W-1:0] d;
    for (int i = 0; i < N; i++) d[i*W +: W] = W'(i + 1);
    run_scan("R3", 1'b0, 1'b0, d, '0);
    check_int("R3", "sum of 1..4", int'(result_o[3*W +: W]), 10);
  endtask

  task automatic t_add_segments();
    logic [N*W-1:0] d;
    for (int i = 0; i < N; i++) d[i*W +: W] = W'(10 * i + 3);
    run_scan("R4", 1'b0, 1'b0, d, 8'b0100_1000);
  endtask

  task automatic t_all_heads();
    logic [N*W-1:0] d;
    for (int i = 0; i < N; i++) d[i*W +: W] = W'(16'h1111 * (i + 1));
    run_scan("R4", 1'b0, 1'b0, d, '1);
    check_vec("R4", "all heads pass through", result_o, d);
  endtask

  task automatic t_first_lane();
    logic [N*W-1:0] d;
    for (int i = 0; i < N; i++) d[i*W +: W] = W'(16'hFF00 - i);
    run_scan("R2", 1'b0, 1'b0, d, 8'b0000_0001);
    check_int("R2", "lane 0 own value", int'(result_o[W-1:0]), int'(d[W-1:0]));
    run_scan("R2", 1'b0, 1'b1, d, '0);
    check_int("R2", "top lane own value (reversed)",
              int'(result_o[(N-1)*W +: W]), int'(d[(N-1)*W +: W]));
  endtask

  task automatic t_copy();
    logic [N*W-1:0] d;
    for (int i = 0; i < N; i++) d[i*W +: W] = W'(16'hA000 + 7 * i);
    run_scan("R5", 1'b1, 1'b0, d, 8'b0010_0100);
    run_scan("R5", 1'b1, 1'b0, d, 8'b1000_0001);
  endtask

  task automatic t_reverse();
    logic [N*W-1:0] d;
    for (int i = 0; i < N; i++) d[i*W +: W] = W'(i * i + 1);
    run_scan("R6", 1'b0, 1'b1, d, '0);
    run_scan("R6", 1'b0, 1'b1, d, 8'b0001_0010);
    run_scan("R6", 1'b1, 1'b1, d, 8'b0100_0100);
  endtask

  task automatic t_wrap();
    logic [N*W-1:0] d;
    for (int i = 0; i < N; i++) d[i*W +: W] = 16'h7FFF;
    d[5*W +: W] = 16'hFFFF;
    run_scan("R3", 1'b0, 1'b0, d, '0);
    check_int("R3", "wrapped lane 1", int'(result_o[W +: W]), 16'hFFFE);
  endtask

  task automatic t_busy_start();
    logic [N*W-1:0] a, b, exp;
    int dones;
    for (int i = 0; i < N; i++) begin
      a[i*W +: W] = W'(i + 2);
      b[i*W +: W] = W'(100 * i + 50);
    end
    exp = model(1'b0, 1'b0, a, 8'b0001_0000);
    @(negedge clk);
    start_i = 1'b1; op_i = 1'b0; rev_i = 1'b0; data_i = a; head_i = 8'b0001_0000;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    start_i = 1'b1; op_i = 1'b1; rev_i = 1'b1; data_i = b; head_i = '0;
    @(negedge clk);
    start_i = 1'b0;
    dones = 0;
    for (int c = 0; c < 4 * (LOGN + 2); c++) begin
      if (done_o) begin
        dones++;
        check_vec("R7", "result of first start", result_o, exp);
      end
      @(negedge clk);
    end
    check_int("R7", "done pulses for two starts during busy", dones, 1);
  endtask

  task automatic t_hold();
    logic [N*W-1:0] keep;
    keep = result_o;
    @(negedge clk);
    data_i = ~data_i; head_i = ~head_i; op_i = ~op_i; rev_i = ~rev_i;
    for (int c = 0; c < 2 * (LOGN + 2); c++) begin
      @(negedge clk);
      if (done_o) begin
        n_tests++; n_fail++;
        $display("FAIL R8 done without start: actual 1 expected 0");
      end
    end
    check_vec("R8", "result held without start", result_o, keep);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL R1 watchdog expired: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; start_i = 1'b0; op_i = 1'b0; rev_i = 1'b0;
    data_i = '0; head_i = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_add_plain();
    t_add_segments();
    t_all_heads();
    t_first_lane();
    t_copy();
    t_reverse();
    t_wrap();
    t_busy_start();
    t_hold();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule